// File: doc/BRIEF.md
# Column-Wise CAM Write Sequencer

This controller stores one search word into a single column of a transposed content-addressable array. In that array each stored word runs down a column and every bit of the word sits on its own row. A column is written by driving the word onto the row enables instead of the bit lines. Rows that must hold a 1 and rows that must hold a 0 are written in separate cycles. In ternary mode a third cycle writes the masked positions. During each write cycle only the target column gets strongly driven bit lines and the reduced cell supply. Every other column stays at full supply, so its contents are protected.

A request carries a column address, a data word, a mask word and three mode flags: ternary, ones-only and clear-all. The controller answers with `busy` while it sequences and pulses `done` once the request has finished. For bulk loading, the array is first cleared in a single cycle with `clr_all`. After that, each column needs only its 1s, written with `ones_only`, which saves one cycle per column. Supply levels are not modelled as analog values. The reduced-supply choice and the under-driven word-line level appear as digital control outputs.

Top module: `cam_colwrite_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `wl_low`, `row_en`, `drv_en`, `vlo_sel` and `bl_val` are all 0.
- R2: A binary write (all flags 0) takes two write cycles. In the first, `row_en` equals the data word and `bl_val` is 1 on the selected column. In the second, `row_en` equals the inverted data word and `bl_val` is all 0.
- R3: A ternary write (`tern`=1) takes three write cycles on a column pair. In the first, `row_en` = data AND NOT mask and both columns drive 1. In the second, `row_en` = NOT data AND NOT mask and both columns drive 0. In the third, `row_en` = mask, the even column drives 0 and the odd column drives 1.
- R4: In a binary write, `drv_en` is the one-hot code of `col_addr` in every write cycle. In a ternary write, `drv_en` has bits 2k and 2k+1 set, where k is `col_addr` modulo COLS/2. `vlo_sel` equals `drv_en` in every cycle, and no other column is driven or placed on the reduced supply.
- R5: `wl_low` is 1 in exactly the write cycles.
- R6: A clear request (`clr_all`=1) takes one write cycle. In it, `row_en`, `drv_en` and `vlo_sel` are all ones and `bl_val` is all 0.
- R7: A binary request with `ones_only`=1 takes one write cycle, equal to the first cycle of R2.
- R8: `busy` is 1 from the cycle after a request is accepted through the last write cycle. A request is accepted only at a clock edge where `busy` is 0. A request raised while `busy` is 1 changes neither the running sequence nor its operands.
- R9: `done` is 1 for exactly the one cycle after the last write cycle. In that cycle `busy` is 0 and every enable, select and bit-line output is 0.
- R10: When several flags are set, `clr_all` takes precedence over `tern`, and `tern` takes precedence over `ones_only`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Write request, sampled when idle |
| tern | input | 1 | Ternary mode: the word occupies a column pair |
| ones_only | input | 1 | Write only the 1s (bulk load after a clear) |
| clr_all | input | 1 | Clear the whole array to 0 |
| col_addr | input | $clog2(COLS) | Target column (binary) or pair index (ternary) |
| wr_data | input | ROWS | Word to store, one bit per row |
| wr_mask | input | ROWS | Don't-care positions for ternary mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| row_en | output | ROWS | Row enables for the current write cycle |
| drv_en | output | COLS | Write-driver and strong bit-line enable per column |
| vlo_sel | output | COLS | Reduced cell supply select per column |
| bl_val | output | COLS | Value driven on the bit lines of enabled columns |
| wl_low | output | 1 | Row enables use the under-driven level |

## Verification
The hardest condition to reach from the ports is a request arriving while a sequence is still running, especially with operands that differ from the ones already latched. With such a request, a faulty design could restart the sequence or take the new operands partway through. The stimulus holds `req` high with fresh random data, mask, address and flags during every busy cycle except the last. The per-cycle row and column patterns must still match the original request. The mode flags are drawn at random, so all three flags are sometimes set together, which exercises the precedence order. All-ones and all-zeros data and masks are added to cover empty row-enable cycles.

// File: rtl/cam_colwrite_pkg.sv
// Shared types for the column-wise CAM write sequencer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package cam_colwrite_pkg;

    // Write phase currently applied to the array
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ONES = 3'd1,
        PH_ZERO = 3'd2,
        PH_MASK = 3'd3,
        PH_CLR  = 3'd4
    } wr_phase_t;

endpackage

// File: rtl/cam_colwrite_coldec.sv
// Column decoder: turns a column address into the set of columns under write.
// Binary mode gives a one-hot code. Ternary mode marks the pair 2k, 2k+1.
// Assumes COLS is a power of two and at least 4.
module cam_colwrite_coldec #(
    parameter int COLS = 8,
    localparam int AW  = $clog2(COLS)
) (
    input  logic [AW-1:0]   addr,
    input  logic            tern,
    output logic [COLS-1:0] hit
);

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            // Match this column against the address in the active mode
            always_comb begin
                if (tern)
                    hit[c] = ((c / 2) == int'(addr[AW-2:0]));
                else
                    hit[c] = (c == int'(addr));
            end
        end
    endgenerate

endmodule

// File: rtl/cam_colwrite_phase.sv
// Phase controller: accepts a request when idle, latches the mode flags and
// steps through the write phases. It then returns to idle and pulses done.
// Assumes the request flags are valid in the cycle req is high.
module cam_colwrite_phase
    import cam_colwrite_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      tern,
    input  logic      ones_only,
    input  logic      clr_all,
    output logic      accept,
    output wr_phase_t phase,
    output logic      tern_q,
    output logic      busy,
    output logic      done
);

    logic      ones_q;
    wr_phase_t phase_nx;

    assign accept = req && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);

    // Next phase from the current phase and the latched flags
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (accept) phase_nx = clr_all ? PH_CLR : PH_ONES;
            PH_ONES: phase_nx = (ones_q && !tern_q) ? PH_IDLE : PH_ZERO;
            PH_ZERO: phase_nx = tern_q ? PH_MASK : PH_IDLE;
            PH_MASK: phase_nx = PH_IDLE;
            PH_CLR:  phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register, flag latch and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            tern_q <= 1'b0;
            ones_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= busy && (phase_nx == PH_IDLE);
            if (accept) begin
                tern_q <= tern && !clr_all;
                ones_q <= ones_only && !clr_all;
            end
        end
    end

    // R2: a binary two-cycle write moves from the 1s cycle to the 0s cycle
    p_ones_then_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ONES && !ones_q) |=> (phase == PH_ZERO));

    // R3: the mask cycle only ever follows a 0s cycle of a ternary write
    p_mask_after_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MASK) |-> ($past(phase) == PH_ZERO) && tern_q);

    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows the final busy cycle and comes with busy low
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

endmodule

// File: rtl/cam_colwrite_seq.sv
// Column-wise CAM write sequencer (top). It latches the operands on
// acceptance and turns the current phase into row enables, column
// driver enables, reduced-supply selects and bit-line values.
// Assumes the array applies the under-driven word-line level when wl_low is high.
module cam_colwrite_seq
    import cam_colwrite_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int AW  = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            tern,
    input  logic            ones_only,
    input  logic            clr_all,
    input  logic [AW-1:0]   col_addr,
    input  logic [ROWS-1:0] wr_data,
    input  logic [ROWS-1:0] wr_mask,
    output logic            busy,
    output logic            done,
    output logic [ROWS-1:0] row_en,
    output logic [COLS-1:0] drv_en,
    output logic [COLS-1:0] vlo_sel,
    output logic [COLS-1:0] bl_val,
    output logic            wl_low
);

    logic            accept;
    logic            tern_q;
    wr_phase_t       phase;
    logic [AW-1:0]   addr_q;
    logic [ROWS-1:0] data_q;
    logic [ROWS-1:0] mask_q;
    logic [COLS-1:0] col_hit;
    logic [COLS-1:0] odd_cols;
    logic [ROWS-1:0] care;

    cam_colwrite_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .tern      (tern),
        .ones_only (ones_only),
        .clr_all   (clr_all),
        .accept    (accept),
        .phase     (phase),
        .tern_q    (tern_q),
        .busy      (busy),
        .done      (done)
    );

    cam_colwrite_coldec #(.COLS(COLS)) u_dec (
        .addr (addr_q),
        .tern (tern_q),
        .hit  (col_hit)
    );

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_odd
            assign odd_cols[c] = (c % 2) == 1;
        end
    endgenerate

    // Operand latch, loaded only when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else if (accept) begin
            addr_q <= col_addr;
            data_q <= wr_data;
            mask_q <= wr_mask;
        end
    end

    assign care = tern_q ? ~mask_q : '1;

    // Phase to array controls
    always_comb begin
        row_en  = '0;
        drv_en  = '0;
        bl_val  = '0;
        wl_low  = 1'b0;
        case (phase)
            PH_ONES: begin
                row_en = data_q & care;
                drv_en = col_hit;
                bl_val = col_hit;
                wl_low = 1'b1;
            end
            PH_ZERO: begin
                row_en = ~data_q & care;
                drv_en = col_hit;
                wl_low = 1'b1;
            end
            PH_MASK: begin
                row_en = mask_q;
                drv_en = col_hit;
                bl_val = col_hit & odd_cols;
                wl_low = 1'b1;
            end
            PH_CLR: begin
                row_en = '1;
                drv_en = '1;
                wl_low = 1'b1;
            end
            default: ;
        endcase
        vlo_sel = drv_en;
    end

    // R4: a binary write selects exactly one column
    p_one_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_CLR && !tern_q) |-> ($countones(drv_en) == 1));

    // R4: a ternary write selects exactly two columns
    p_pair_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tern_q) |-> ($countones(vlo_sel) == 2));

    // R5: the reduced word-line level is applied only while writing
    p_wl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wl_low == busy);

    // R8: operands stay frozen while a sequence is running
    p_hold_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(data_q) && $stable(mask_q) && $stable(addr_q)));

    // R9: outputs return to idle when done pulses
    p_idle_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (row_en == '0 && drv_en == '0 && vlo_sel == '0 && bl_val == '0));

endmodule

// File: tb/cam_colwrite_seq_tb_top.sv
// Self-checking bench for the column-wise CAM write sequencer.
// It mixes random requests (fixed seed) with directed corner cases.
module cam_colwrite_seq_tb_top;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int AW   = $clog2(COLS);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req, tern, ones_only, clr_all;
    logic [AW-1:0]   col_addr;
    logic [ROWS-1:0] wr_data, wr_mask;
    logic            busy, done, wl_low;
    logic [ROWS-1:0] row_en;
    logic [COLS-1:0] drv_en, vlo_sel, bl_val;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cam_colwrite_seq #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .tern(tern),
        .ones_only(ones_only), .clr_all(clr_all), .col_addr(col_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .busy(busy), .done(done),
        .row_en(row_en), .drv_en(drv_en), .vlo_sel(vlo_sel),
        .bl_val(bl_val), .wl_low(wl_low)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [COLS-1:0] exp_sel(input logic t, input logic [AW-1:0] a);
        if (t) return COLS'(2'b11) << (2 * (a % (COLS / 2)));
        return COLS'(1) << a;
    endfunction

    // Number of write cycles implied by the flags (precedence clr > tern > ones)
    function automatic int exp_len(input logic t, input logic o, input logic c);
        if (c) return 1;
        if (t) return 3;
        if (o) return 1;
        return 2;
    endfunction

    function automatic logic [ROWS-1:0] exp_row(input int k, input logic t, input logic c,
                                                input logic [ROWS-1:0] d, input logic [ROWS-1:0] m);
        logic [ROWS-1:0] cm;
        if (c) return '1;
        cm = t ? ~m : '1;
        if (k == 0) return d & cm;
        if (k == 1) return ~d & cm;
        return m;
    endfunction

    function automatic logic [COLS-1:0] exp_bl(input int k, input logic c, input logic [COLS-1:0] s);
        if (c) return '0;
        if (k == 0) return s;
        if (k == 1) return '0;
        return s & {(COLS/2){2'b10}};
    endfunction

    task automatic idle_inputs();
        req = 0; tern = 0; ones_only = 0; clr_all = 0;
        col_addr = '0; wr_data = '0; wr_mask = '0;
    endtask

    // Issue one request and check every cycle until done has cleared
    task automatic do_op(input logic t, input logic o, input logic c,
                         input logic [AW-1:0] a, input logic [ROWS-1:0] d,
                         input logic [ROWS-1:0] m, input bit noise);
        int n;
        logic tt;
        logic [COLS-1:0] s;
        n  = exp_len(t, o, c);
        tt = t && !c;
        s  = c ? '1 : exp_sel(tt, a);
        @(negedge clk);
        req = 1; tern = t; ones_only = o; clr_all = c;
        col_addr = a; wr_data = d; wr_mask = m;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R8", "busy in write cycle", 64'(busy), 64'(1));
            check("R5", "wl_low in write cycle", 64'(wl_low), 64'(1));
            check(c ? "R6" : (tt ? "R3" : "R2"), "row_en",
                  64'(row_en), 64'(exp_row(k, tt, c, d, m)));
            check("R4", "drv_en", 64'(drv_en), 64'(s));
            check("R4", "vlo_sel", 64'(vlo_sel), 64'(s));
            check(c ? "R6" : (tt ? "R3" : "R2"), "bl_val",
                  64'(bl_val), 64'(exp_bl(k, c, s)));
            check("R9", "no early done", 64'(done), 64'(0));
            if (noise && k < n - 1) begin
                req = 1; tern = 1'($urandom); ones_only = 1'($urandom);
                clr_all = 1'($urandom); col_addr = AW'($urandom);
                wr_data = ROWS'($urandom); wr_mask = ROWS'($urandom);
            end else begin
                idle_inputs();
            end
        end
        @(negedge clk);
        check("R9", "done pulse", 64'(done), 64'(1));
        check("R9", "busy low at done", 64'(busy), 64'(0));
        check("R9", "outputs idle at done",
              64'({row_en, drv_en, vlo_sel, bl_val, wl_low}), 64'(0));
        @(negedge clk);
        check("R9", "done one cycle", 64'(done), 64'(0));
        check("R8", "no extra op after noise", 64'(busy), 64'(0));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", "busy", 64'(busy), 64'(0));
        check("R1", "done", 64'(done), 64'(0));
        check("R1", "outputs",
              64'({row_en, drv_en, vlo_sel, bl_val, wl_low}), 64'(0));

        // Directed corners
        do_op(0, 0, 0, 3'd5, 8'hA5, 8'h00, 0);      // R2 binary
        do_op(0, 1, 0, 3'd0, 8'hF0, 8'h00, 0);      // R7 ones-only
        do_op(0, 0, 1, 3'd2, 8'h3C, 8'hFF, 0);      // R6 clear
        do_op(1, 0, 0, 3'd7, 8'hC3, 8'h18, 0);      // R3 ternary, pair 6/7
        do_op(1, 0, 0, 3'd1, 8'hFF, 8'hFF, 0);      // R3 all masked
        do_op(1, 1, 0, 3'd2, 8'h0F, 8'h00, 0);      // R10 tern over ones_only
        do_op(1, 1, 1, 3'd4, 8'h12, 8'h34, 0);      // R10 clear wins
        do_op(0, 0, 0, 3'd7, 8'h00, 8'h00, 1);      // R8 requests while busy
        do_op(0, 0, 0, 3'd3, 8'hFF, 8'h00, 1);      // R2 all ones data

        // Random mix
        for (int i = 0; i < 80; i++) begin
            do_op(1'($urandom), 1'($urandom), 1'(($urandom % 5) == 0),
                  AW'($urandom), ROWS'($urandom), ROWS'($urandom),
                  1'($urandom));
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule